// File: doc/BRIEF.md
# Bundled-Slot Stack Processor Core

This block is a small 16-bit processor that executes a packed instruction stream against a register-based evaluation stack. Each program word holds four 4-bit operations. The core reads one such word and then runs its four slots in turn, most significant slot first, one clock per slot. The push-constant operation takes its 16-bit value from the program words that directly follow the current bundle. Several constants in one bundle consume successive words in slot order, and the next bundle is read from the word after the last constant.

There is no call or return hardware. Software forms a call by pushing a return address, pushing the target and issuing the unconditional jump. The return address is left on the stack for the callee to save. The conditional jumps test the entry beneath the target. With the AND operation, software can mask a sign bit and branch on the result. Memory is reached through a single port. Read data must be valid in the same cycle as the address, and writes take effect on the clock edge. Program addresses and word-operation addresses are word addresses. Byte operations use a byte address: the word address is that value shifted right by one, and address bit 0 picks the byte lane.

Top module: `misc_core`

## Requirements
- R1: While `rst` is high the core issues no write. In the first cycle after `rst` falls, the core reads the bundle at word address 0. All stack entries are zero after reset.
- R2: A bundle takes one read cycle followed by exactly four execution cycles, slot 0 in bits 15:12 first. Opcodes: 0 nop, 1 push-literal, 2 load word, 3 store word, 4 load byte, 5 store byte, 6 add, 7 and, 8 xor, 9 jump, 10 jump-if-zero, 11 jump-if-nonzero.
- R3: Push-literal reads the word at the current program pointer and pushes it. Literals in one bundle take consecutive words after the bundle, and the next bundle is read from the word that follows the last literal.
- R4: Add (modulo 2^16), and, and xor pop the top two entries and push the result.
- R5: Load word replaces the address on top of the stack with the word read there. Store word pops the address from the top and the data from beneath it, and writes with `mem_bsel` = 2'b11.
- R6: Load byte reads word (addr >> 1) and replaces the top with that byte zero-extended, where addr bit 0 = 0 selects bits 7:0 and 1 selects bits 15:8. Store byte writes bits 7:0 of the data into that lane only, with `mem_bsel` = 2'b01 for lane 0 and 2'b10 for lane 1.
- R7: Jump pops only the target and leaves the entries beneath it in place. Every taken jump drops the remaining slots of the bundle, and the next cycle reads the bundle at the target.
- R8: Jump-if-zero and jump-if-nonzero pop the target (top) and the condition (beneath), and are taken when the condition equals zero or differs from zero respectively. When not taken, execution continues with the next slot.
- R9: The stack holds three entries. A push onto a full stack discards the bottom entry, and each pop fills the vacated bottom entry with zero.
- R10: Opcode 0 and opcodes 12 to 15 each take one execution cycle and change neither the stack, the memory nor the program pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address of the current read or write |
| mem_wdata | output | 16 | Write data; for byte stores the byte is copied to both lanes |
| mem_rdata | input | 16 | Read data for `mem_addr`, valid in the same cycle |
| mem_we | output | 1 | Write strobe, applied on the rising edge |
| mem_bsel | output | 2 | Byte lane enables for the write; 2'b11 for a whole word |

## Verification
A wrong slot counter or program pointer shows up on `mem_addr` within one bundle. The next bundle read is then either early, late or at the wrong word, and the cycle of the first store moves accordingly. A corrupted stack entry shows only when it reaches memory through a store. For this reason each scenario ends by storing the entries it depends on, including the zero-filled bottom entry, and the bench compares memory words and store timing. A slot that should have been dropped after a taken jump shows as a write to a guard word that must keep its preset value.

// File: rtl/misc_pkg.sv
package misc_pkg;

    localparam int OP_W = 4;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LIT  = 4'd1,
        OP_LDW  = 4'd2,
        OP_STW  = 4'd3,
        OP_LDB  = 4'd4,
        OP_STB  = 4'd5,
        OP_ADD  = 4'd6,
        OP_AND  = 4'd7,
        OP_XOR  = 4'd8,
        OP_JMP  = 4'd9,
        OP_JZ   = 4'd10,
        OP_JNZ  = 4'd11
    } op_e;

    typedef enum logic [2:0] {
        SK_HOLD,
        SK_PUSH,
        SK_REPL,
        SK_POP1,
        SK_BIN,
        SK_POP2
    } stk_op_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_AND,
        ALU_XOR
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_BYTE,
        SRC_ALU
    } dsrc_e;

    typedef enum logic [1:0] {
        JK_NONE,
        JK_ALWAYS,
        JK_ZERO,
        JK_NONZERO
    } jkind_e;

    typedef struct packed {
        stk_op_e stk;
        dsrc_e   src;
        alu_op_e alu;
        logic    lit;
        logic    word_acc;
        logic    byte_acc;
        logic    we;
        jkind_e  jmp;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OP_W-1:0] op);
        ctl_t c;
        c = '{stk: SK_HOLD, src: SRC_MEM, alu: ALU_ADD, lit: 1'b0,
              word_acc: 1'b0, byte_acc: 1'b0, we: 1'b0, jmp: JK_NONE};
        case (op)
            OP_LIT: begin c.stk = SK_PUSH; c.lit = 1'b1; end
            OP_LDW: begin c.stk = SK_REPL; c.word_acc = 1'b1; end
            OP_STW: begin c.stk = SK_POP2; c.word_acc = 1'b1; c.we = 1'b1; end
            OP_LDB: begin c.stk = SK_REPL; c.byte_acc = 1'b1; c.src = SRC_BYTE; end
            OP_STB: begin c.stk = SK_POP2; c.byte_acc = 1'b1; c.we = 1'b1; end
            OP_ADD: begin c.stk = SK_BIN; c.src = SRC_ALU; c.alu = ALU_ADD; end
            OP_AND: begin c.stk = SK_BIN; c.src = SRC_ALU; c.alu = ALU_AND; end
            OP_XOR: begin c.stk = SK_BIN; c.src = SRC_ALU; c.alu = ALU_XOR; end
            OP_JMP: begin c.stk = SK_POP1; c.jmp = JK_ALWAYS; end
            OP_JZ:  begin c.stk = SK_POP2; c.jmp = JK_ZERO; end
            OP_JNZ: begin c.stk = SK_POP2; c.jmp = JK_NONZERO; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/misc_alu.sv
module misc_alu
    import misc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  alu_op_e           op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_XOR: y = a ^ b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/misc_stack.sv
module misc_stack
    import misc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] tos,
    output logic [WORD_W-1:0] nos
);
    logic [WORD_W-1:0] ent   [DEPTH];
    logic [WORD_W-1:0] down1 [DEPTH];
    logic [WORD_W-1:0] up1   [DEPTH];
    logic [WORD_W-1:0] up2   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_shift
        if (i == 0) begin : g_d0
            assign down1[i] = din;
        end else begin : g_dn
            assign down1[i] = ent[i-1];
        end
        if (i + 1 < DEPTH) begin : g_u1
            assign up1[i] = ent[i+1];
        end else begin : g_u1z
            assign up1[i] = '0;
        end
        if (i + 2 < DEPTH) begin : g_u2
            assign up2[i] = ent[i+2];
        end else begin : g_u2z
            assign up2[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            case (op)
                SK_PUSH: for (int i = 0; i < DEPTH; i++) ent[i] <= down1[i];
                SK_REPL: ent[0] <= din;
                SK_POP1: for (int i = 0; i < DEPTH; i++) ent[i] <= up1[i];
                SK_BIN: begin
                    ent[0] <= din;
                    for (int i = 1; i < DEPTH; i++) ent[i] <= up1[i];
                end
                SK_POP2: for (int i = 0; i < DEPTH; i++) ent[i] <= up2[i];
                default: ;
            endcase
        end
    end

    assign tos = ent[0];
    assign nos = ent[1];
endmodule

// File: rtl/misc_seq.sv
module misc_seq
    import misc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rdata,
    input  logic              lit_step,
    input  logic              jump_take,
    input  logic [WORD_W-1:0] jump_tgt,
    output logic              fetching,
    output logic [WORD_W-1:0] pc,
    output logic [OP_W-1:0]   cur_op
);
    localparam int SLOTS = WORD_W / OP_W;
    localparam int SL_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic              fetch_q;
    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] bundle_q;
    logic [SL_W-1:0]   slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q  <= 1'b1;
            pc_q     <= '0;
            bundle_q <= '0;
            slot_q   <= '0;
        end else if (fetch_q) begin
            fetch_q  <= 1'b0;
            bundle_q <= rdata;
            pc_q     <= pc_q + WORD_W'(1);
            slot_q   <= '0;
        end else if (jump_take) begin
            fetch_q  <= 1'b1;
            pc_q     <= jump_tgt;
        end else begin
            if (lit_step) pc_q <= pc_q + WORD_W'(1);
            bundle_q <= bundle_q << OP_W;
            if (slot_q == SL_W'(SLOTS - 1)) begin
                fetch_q <= 1'b1;
            end else begin
                slot_q <= slot_q + SL_W'(1);
            end
        end
    end

    assign fetching = fetch_q;
    assign pc       = pc_q;
    assign cur_op   = bundle_q[WORD_W-1 -: OP_W];
endmodule

// File: rtl/misc_core.sv
module misc_core
    import misc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 3
) (
    input  logic                clk,
    input  logic                rst,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                mem_we,
    output logic [WORD_W/8-1:0] mem_bsel
);
    localparam int SLOTS = WORD_W / OP_W;
    localparam int LANES = WORD_W / 8;
    localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;

    logic              fetching;
    logic [WORD_W-1:0] pc;
    logic [OP_W-1:0]   cur_op;
    logic [WORD_W-1:0] tos;
    logic [WORD_W-1:0] nos;
    logic [WORD_W-1:0] alu_y;
    logic [WORD_W-1:0] stk_din;
    logic [7:0]        rd_byte;
    logic [LB-1:0]     lane;
    logic              jump_take;
    stk_op_e           stk_op;
    ctl_t              ctl;

    assign ctl  = fetching ? decode_op(OP_NOP) : decode_op(cur_op);
    assign lane = tos[LB-1:0];
    assign rd_byte = mem_rdata[int'(lane)*8 +: 8];

    misc_seq #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rdata    (mem_rdata),
        .lit_step (ctl.lit),
        .jump_take(jump_take),
        .jump_tgt (tos),
        .fetching (fetching),
        .pc       (pc),
        .cur_op   (cur_op)
    );

    misc_alu #(.WORD_W(WORD_W)) u_alu (
        .op(ctl.alu),
        .a (nos),
        .b (tos),
        .y (alu_y)
    );

    misc_stack #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_stack (
        .clk(clk),
        .rst(rst),
        .op (stk_op),
        .din(stk_din),
        .tos(tos),
        .nos(nos)
    );

    always_comb begin
        case (ctl.jmp)
            JK_ALWAYS:  jump_take = 1'b1;
            JK_ZERO:    jump_take = (nos == '0);
            JK_NONZERO: jump_take = (nos != '0);
            default:    jump_take = 1'b0;
        endcase
    end

    always_comb begin
        stk_op = ctl.stk;
        case (ctl.src)
            SRC_ALU:  stk_din = alu_y;
            SRC_BYTE: stk_din = WORD_W'(rd_byte);
            default:  stk_din = mem_rdata;
        endcase
    end

    always_comb begin
        if (ctl.word_acc) begin
            mem_addr = tos;
        end else if (ctl.byte_acc) begin
            mem_addr = tos >> LB;
        end else begin
            mem_addr = pc;
        end
        mem_we = ctl.we;
        if (ctl.byte_acc) begin
            mem_wdata = {LANES{nos[7:0]}};
            mem_bsel  = LANES'(1) << lane;
        end else begin
            mem_wdata = nos;
            mem_bsel  = '1;
        end
    end
endmodule

// File: rtl/misc_core_chk.sv
module misc_core_chk #(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              fetching,
    input logic [WORD_W-1:0] pc,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              jump_take
);
    localparam int CW = $clog2(SLOTS) + 2;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || fetching) run_cnt <= '0;
        else                 run_cnt <= run_cnt + CW'(1);
    end

    assert_reset_vector_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetching && mem_addr == '0));

    assert_no_write_in_reset_R1: assert property (@(posedge clk)
        rst |-> !mem_we);

    assert_fetch_then_exec_R2: assert property (@(posedge clk) disable iff (rst)
        fetching |=> !fetching);

    assert_bundle_len_R2: assert property (@(posedge clk) disable iff (rst)
        !fetching |-> (run_cnt < CW'(SLOTS)));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        fetching |=> (pc == $past(pc) + WORD_W'(1)));

    assert_no_store_in_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !fetching);

    assert_jump_refetch_R7: assert property (@(posedge clk) disable iff (rst)
        jump_take |=> fetching);
endmodule

bind misc_core misc_core_chk #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fetching (fetching),
    .pc       (pc),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .jump_take(jump_take)
);

// File: tb/misc_core_tb.sv
`timescale 1ns/1ps
module misc_core_tb;
    localparam logic [3:0] NOP = 4'd0, LIT = 4'd1, LDW = 4'd2, STW = 4'd3,
                           LDB = 4'd4, STB = 4'd5, ADD = 4'd6, AND = 4'd7,
                           XOR = 4'd8, JMP = 4'd9, JZ = 4'd10, JNZ = 4'd11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;
    logic [1:0]  mem_bsel;

    logic [15:0] mem [256];
    int n_chk = 0, n_fail = 0;
    int cyc = 0, wd = 0, first_we = -1;
    logic [15:0] addr_log [32];

    always #4 clk = ~clk;

    misc_core u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_bsel(mem_bsel)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_bsel[0]) mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
            if (mem_bsel[1]) mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
        end
        cyc <= rst ? 0 : cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (cyc < 32) addr_log[cyc] = mem_addr;
            if (mem_we && first_we < 0) first_we = cyc;
        end
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tiny assembler
    logic [3:0]  p_ops [4];
    logic [15:0] p_lits [4];
    int p_n = 0, l_n = 0, ptr = 0;

    task automatic asm_clear();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        p_n = 0; l_n = 0; ptr = 0;
    endtask

    task automatic asm_flush();
        if (p_n == 0) return;
        for (int i = p_n; i < 4; i++) p_ops[i] = NOP;
        mem[ptr] = {p_ops[0], p_ops[1], p_ops[2], p_ops[3]};
        ptr = ptr + 1;
        for (int i = 0; i < l_n; i++) begin
            mem[ptr] = p_lits[i];
            ptr = ptr + 1;
        end
        p_n = 0; l_n = 0;
    endtask

    task automatic op(input logic [3:0] o, input logic [15:0] v = 16'h0);
        p_ops[p_n] = o;
        if (o == LIT) begin
            p_lits[l_n] = v;
            l_n = l_n + 1;
        end
        p_n = p_n + 1;
        if (p_n == 4) asm_flush();
    endtask

    task automatic asm_org(input int a);
        asm_flush();
        ptr = a;
    endtask

    task automatic asm_halt();
        int a;
        asm_flush();
        a = ptr;
        op(LIT, 16'(a));
        op(JMP);
        asm_flush();
    endtask

    task automatic run_prog(input int n);
        first_we = -1;
        for (int i = 0; i < 32; i++) addr_log[i] = 16'hxxxx;
        @(negedge clk);
        chk("R1 no write during reset", {15'b0, mem_we}, 16'h0);
        rst = 1'b0;
        repeat (n) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_literals();
        asm_clear();
        op(LIT, 16'h1111); op(LIT, 16'h5A5A); op(LIT, 16'h0080); op(STW);
        op(LIT, 16'h0081); op(STW);
        asm_halt();
        run_prog(60);
        chk("R1 first read at word 0", addr_log[0], 16'h0000);
        chk("R3 second literal word", addr_log[2], 16'h0002);
        chk("R2 store in fourth slot cycle", 16'(first_we), 16'd4);
        chk("R3 next bundle after literals", addr_log[5], 16'h0004);
        chk("R5 store word order", mem[8'h80], 16'h5A5A);
        chk("R3 first literal kept", mem[8'h81], 16'h1111);
    endtask

    task automatic t_alu();
        asm_clear();
        op(LIT, 16'hFFF0); op(LIT, 16'h0025); op(ADD); op(LIT, 16'h0090); op(STW);
        op(LIT, 16'hF0F0); op(LIT, 16'h3C3C); op(AND); op(LIT, 16'h0091); op(STW);
        op(LIT, 16'h00FF); op(LIT, 16'h0F0F); op(XOR); op(LIT, 16'h0092); op(STW);
        asm_halt();
        run_prog(120);
        chk("R4 add wraps", mem[8'h90], 16'h0015);
        chk("R4 and", mem[8'h91], 16'h3030);
        chk("R4 xor", mem[8'h92], 16'h0FF0);
    endtask

    task automatic t_words();
        asm_clear();
        op(LIT, 16'h00A0); op(LDW); op(LIT, 16'h00A1); op(STW);
        op(LIT, 16'h7777); op(LIT, 16'h00A0); op(LDW); op(ADD);
        op(LIT, 16'h00A2); op(STW);
        asm_halt();
        mem[8'hA0] = 16'h1234;
        run_prog(100);
        chk("R5 load then store word", mem[8'hA1], 16'h1234);
        chk("R5 load replaces top", mem[8'hA2], 16'h89AB);
    endtask

    task automatic t_bytes();
        asm_clear();
        op(LIT, 16'h0160); op(LDB); op(LIT, 16'h00B1); op(STW);
        op(LIT, 16'h0161); op(LDB); op(LIT, 16'h00B2); op(STW);
        op(LIT, 16'h1234); op(LIT, 16'h0166); op(STB);
        op(LIT, 16'hAB56); op(LIT, 16'h0169); op(STB);
        asm_halt();
        mem[8'hB0] = 16'hC3A5;
        mem[8'hB3] = 16'hFFFF;
        mem[8'hB4] = 16'hFFFF;
        run_prog(120);
        chk("R6 load byte lane 0", mem[8'hB1], 16'h00A5);
        chk("R6 load byte lane 1", mem[8'hB2], 16'h00C3);
        chk("R6 store byte lane 0", mem[8'hB3], 16'hFF34);
        chk("R6 store byte lane 1", mem[8'hB4], 16'h56FF);
    endtask

    task automatic t_jump();
        asm_clear();
        op(LIT, 16'h42F0); op(LIT, 16'h0040); op(JMP); op(STW);
        asm_org(16'h40);
        op(LIT, 16'h00C0); op(STW);
        asm_halt();
        mem[8'hF0] = 16'h5555;
        run_prog(80);
        chk("R7 refetch at target", addr_log[4], 16'h0040);
        chk("R7 slot after jump dropped", mem[8'hF0], 16'h5555);
        chk("R7 return value kept", mem[8'hC0], 16'h42F0);
    endtask

    task automatic t_cond();
        asm_clear();
        op(LIT, 16'h8001); op(LIT, 16'h8000); op(AND); op(LIT, 16'h0030); op(JZ);
        op(LIT, 16'h0001); op(LIT, 16'h00D0); op(STW);
        op(LIT, 16'h7FFF); op(LIT, 16'h8000); op(AND); op(LIT, 16'h0050); op(JZ);
        op(LIT, 16'h0002); op(LIT, 16'h00D1); op(STW);
        asm_halt();
        asm_org(16'h30);
        op(LIT, 16'h0007); op(LIT, 16'h00D6); op(STW);
        asm_halt();
        asm_org(16'h50);
        op(LIT, 16'h0006); op(LIT, 16'h00D4); op(STW);
        op(LIT, 16'h0003); op(LIT, 16'h0060); op(JNZ);
        op(LIT, 16'h0004); op(LIT, 16'h00D2); op(STW);
        asm_halt();
        asm_org(16'h60);
        op(LIT, 16'h0000); op(LIT, 16'h0070); op(JNZ);
        op(LIT, 16'h0005); op(LIT, 16'h00D3); op(STW);
        asm_halt();
        asm_org(16'h70);
        op(LIT, 16'h0009); op(LIT, 16'h00D5); op(STW);
        asm_halt();
        run_prog(200);
        chk("R8 jz not taken on set sign", mem[8'hD0], 16'h0001);
        chk("R8 jz taken skips rest", mem[8'hD1], 16'h0000);
        chk("R8 jz taken reached target", mem[8'hD4], 16'h0006);
        chk("R8 jnz taken skips rest", mem[8'hD2], 16'h0000);
        chk("R8 jnz not taken continues", mem[8'hD3], 16'h0005);
        chk("R8 jnz zero cond not taken", mem[8'hD5], 16'h0000);
        chk("R8 jz nonzero cond not taken", mem[8'hD6], 16'h0000);
    endtask

    task automatic t_depth();
        asm_clear();
        op(LIT, 16'h1111); op(LIT, 16'h2222); op(LIT, 16'h3333); op(LIT, 16'h00E1);
        op(STW); op(LIT, 16'h00E2); op(STW); op(LIT, 16'h00E3); op(STW);
        asm_halt();
        mem[8'hE3] = 16'hFFFF;
        run_prog(100);
        chk("R9 top two after overflow", mem[8'hE1], 16'h3333);
        chk("R9 bottom entry survives", mem[8'hE2], 16'h2222);
        chk("R9 discarded entry and zero fill", mem[8'hE3], 16'h0000);
    endtask

    task automatic t_nops();
        asm_clear();
        op(LIT, 16'h7070); op(LIT, 16'h00E8); op(4'd12); op(4'd13);
        op(4'd14); op(4'd15); op(NOP); op(STW);
        asm_halt();
        run_prog(60);
        chk("R10 spare opcodes one cycle each", 16'(first_we), 16'd9);
        chk("R10 spare opcodes keep stack", mem[8'hE8], 16'h7070);
        chk("R10 bundle read after no-ops", addr_log[5], 16'h0003);
    endtask

    task automatic t_reset();
        asm_clear();
        op(LIT, 16'hBEEF); op(LIT, 16'hCAFE); op(LIT, 16'h1234);
        asm_halt();
        run_prog(40);
        asm_clear();
        op(STW); op(NOP); op(NOP); op(NOP);
        asm_halt();
        run_prog(40);
        chk("R1 stack zero after reset", mem[8'h00], 16'h0000);
        chk("R1 stale entry not stored", mem[8'h34], 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_literals();
        t_alu();
        t_words();
        t_bytes();
        t_jump();
        t_cond();
        t_depth();
        t_nops();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule